// File: doc/BRIEF.md
# Frame Geometry Monitor

This block watches a stream of frame-valid, line-valid and data-valid strobes that has already been brought into the system clock domain. For every frame it measures three things. The first is how many data-valid clocks the last line carried. The second is how many lines the frame held. The third is how many pixels that geometry amounts to once the number of pixels delivered per clock (the tap count) is applied. When the frame closes, the figures are frozen into output registers and announced by a single-cycle done pulse.

Software uses the frozen figures to size its reads so that no partial frame is left behind in the capture path. The block compares the measured width and height with programmed expectations and raises a flag for each one that differs. It also reports whether the geometry suits a wide-word packer. A packer of that kind drains cleanly only when either the clocks per line or the line count is a multiple of 16. A wrapping frame counter ticks once per closed frame.

Top module: `frame_geom_mon`

## Requirements
- R1: While reset is held and until the first frame closes, every result output, every flag, the done pulse and the frame counter read zero.
- R2: The line clock result equals the number of cycles in which line valid and data valid were both high during the last line of the frame; cycles with data valid low inside a line are not counted.
- R3: The line count result equals the number of line-valid rising edges seen while frame valid is high; line-valid pulses while frame valid is low are not counted.
- R4: The pixels-per-line result equals line clocks times the effective tap count, where a tap input of 1 to 10 is used as given, 0 is treated as 1 and anything above 10 is treated as 10.
- R5: The frame pixel total equals pixels per line times the line count, kept to the low 32 bits.
- R6: Frame valid seen low on a clock edge after being high closes the frame: on that edge all results update and the done output goes high for exactly one cycle, and the results then hold until the next frame closes.
- R7: The width error flag is set when pixels per line differs from the expected width input, and the height error flag when the line count differs from the expected height input; both update with the results.
- R8: The alignment flag is set when the line clock result is a multiple of 16 or the line count is a multiple of 16, and cleared otherwise.
- R9: The frame counter increases by one on every done pulse and wraps to zero after its all-ones value.
- R10: Counting restarts at each frame-valid rising edge, so no line or clock from before the frame reaches its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fval_i | input | 1 | Frame valid strobe |
| lval_i | input | 1 | Line valid strobe |
| dval_i | input | 1 | Data valid strobe |
| tap_cnt_i | input | 4 | Pixels delivered per clock, 1 to 10 |
| exp_width_i | input | 20 | Expected pixels per line |
| exp_height_i | input | 16 | Expected lines per frame |
| line_clks_o | output | 16 | Data-valid clocks in the last line |
| frame_lines_o | output | 16 | Lines in the frame |
| line_pixels_o | output | 20 | Pixels per line |
| frame_pixels_o | output | 32 | Pixels per frame |
| width_err_o | output | 1 | Width differs from expectation |
| height_err_o | output | 1 | Height differs from expectation |
| align_ok_o | output | 1 | Geometry drains a wide-word packer cleanly |
| frame_done_o | output | 1 | One-cycle pulse on frame close |
| frame_cnt_o | output | 16 | Wrapping count of closed frames |

## Verification
The embedded properties assume that the last line of a frame ends before frame valid drops. They also assume that the tap count and both expected dimensions are steady on the edge that closes the frame. The line clock result is taken from the line-valid falling edge, so a line still open when the frame ends would not be captured. The stimulus always lowers line valid two cycles before frame valid, and it sets the tap count and expectations before frame valid rises, holding them for several cycles after it falls. Frames use varying stall patterns, a differing last line, out-of-range tap values and stray line pulses between frames, so that the counting rules are exercised within those assumptions.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
  localparam int TAP_W   = 4;
  localparam int TAP_MAX = 10;

  function automatic logic [TAP_W-1:0] eff_tap(input logic [TAP_W-1:0] raw);
    logic [TAP_W-1:0] r;
    if (raw == '0)                   r = TAP_W'(1);
    else if (raw > TAP_W'(TAP_MAX))  r = TAP_W'(TAP_MAX);
    else                             r = raw;
    return r;
  endfunction
endpackage

// File: rtl/fgm_line_clk_cnt.sv
module fgm_line_clk_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lv,
  input  logic             dv,
  input  logic             lv_rise,
  input  logic             lv_fall,
  input  logic             frame_start,
  output logic [CNT_W-1:0] line_clks
);
  logic [CNT_W-1:0] run_q, run_nxt, hold_q, hold_nxt;
  logic             run_en, hold_en;

  always_comb begin
    run_en  = lv_rise | (lv & dv);
    run_nxt = run_q;
    if (lv_rise)       run_nxt = dv ? CNT_W'(1) : '0;
    else if (lv & dv)  run_nxt = run_q + CNT_W'(1);
  end

  always_comb begin
    hold_en  = frame_start | lv_fall;
    hold_nxt = hold_q;
    if (lv_fall)     hold_nxt = run_q;
    if (frame_start) hold_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      if (run_en)  run_q  <= run_nxt;
      if (hold_en) hold_q <= hold_nxt;
    end
  end

  assign line_clks = hold_q;

  // R2
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv || !dv) && !lv_rise |=> $stable(run_q));
endmodule

// File: rtl/fgm_line_num_cnt.sv
module fgm_line_num_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fv,
  input  logic             lv_rise,
  input  logic             frame_start,
  output logic [CNT_W-1:0] lines
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = frame_start | (fv & lv_rise);
    cnt_nxt = cnt_q;
    if (frame_start)         cnt_nxt = lv_rise ? CNT_W'(1) : '0;
    else if (fv & lv_rise)   cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign lines = cnt_q;

  // R3
  stray_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fv |=> $stable(cnt_q));
endmodule

// File: rtl/fgm_result_reg.sv
module fgm_result_reg
  import fgm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PIX_W  = 20,
  parameter int TOT_W  = 32,
  parameter int FCNT_W = 16,
  parameter int ALN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  line_clks,
  input  logic [CNT_W-1:0]  line_num,
  input  logic [TAP_W-1:0]  tap_raw,
  input  logic [PIX_W-1:0]  exp_width,
  input  logic [CNT_W-1:0]  exp_height,
  output logic [CNT_W-1:0]  clks_q,
  output logic [CNT_W-1:0]  lines_q,
  output logic [PIX_W-1:0]  ppl_q,
  output logic [TOT_W-1:0]  total_q,
  output logic              werr_q,
  output logic              herr_q,
  output logic              align_q,
  output logic              done_q,
  output logic [FCNT_W-1:0] fcnt_q
);
  logic [TAP_W-1:0]  tap_c;
  logic [PIX_W-1:0]  ppl_c;
  logic [TOT_W-1:0]  total_c;
  logic              werr_c, herr_c, align_c;
  logic [FCNT_W-1:0] fcnt_nxt;

  always_comb begin
    tap_c    = eff_tap(tap_raw);
    ppl_c    = PIX_W'(line_clks) * PIX_W'(tap_c);
    total_c  = TOT_W'(ppl_c) * TOT_W'(line_num);
    werr_c   = (ppl_c != exp_width);
    herr_c   = (line_num != exp_height);
    align_c  = (line_clks[ALN_W-1:0] == '0) || (line_num[ALN_W-1:0] == '0);
    fcnt_nxt = fcnt_q + FCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clks_q  <= '0;
      lines_q <= '0;
      ppl_q   <= '0;
      total_q <= '0;
      werr_q  <= 1'b0;
      herr_q  <= 1'b0;
      align_q <= 1'b0;
      fcnt_q  <= '0;
    end else if (frame_end) begin
      clks_q  <= line_clks;
      lines_q <= line_num;
      ppl_q   <= ppl_c;
      total_q <= total_c;
      werr_q  <= werr_c;
      herr_q  <= herr_c;
      align_q <= align_c;
      fcnt_q  <= fcnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= frame_end;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(lines_q) && $stable(clks_q) && $stable(total_q));

  // R9
  fcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> fcnt_q == $past(fcnt_q) + FCNT_W'(1));

  // R4
  ppl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ppl_q >= PIX_W'(clks_q)) &&
               (ppl_q <= PIX_W'(clks_q) * PIX_W'(TAP_MAX)));
endmodule

// File: rtl/frame_geom_mon.sv
module frame_geom_mon
  import fgm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TOT_W  = 32,
  parameter int FCNT_W = 16,
  parameter int ALN_W  = 4,
  localparam int PIX_W = CNT_W + TAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fval_i,
  input  logic              lval_i,
  input  logic              dval_i,
  input  logic [TAP_W-1:0]  tap_cnt_i,
  input  logic [PIX_W-1:0]  exp_width_i,
  input  logic [CNT_W-1:0]  exp_height_i,
  output logic [CNT_W-1:0]  line_clks_o,
  output logic [CNT_W-1:0]  frame_lines_o,
  output logic [PIX_W-1:0]  line_pixels_o,
  output logic [TOT_W-1:0]  frame_pixels_o,
  output logic              width_err_o,
  output logic              height_err_o,
  output logic              align_ok_o,
  output logic              frame_done_o,
  output logic [FCNT_W-1:0] frame_cnt_o
);
  logic       rst_meta, rst_sync_n;
  logic       fv_q, lv_q;
  logic       frame_start, frame_end, lv_rise, lv_fall;
  logic [CNT_W-1:0] cur_clks, cur_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fv_q <= 1'b0;
      lv_q <= 1'b0;
    end else begin
      fv_q <= fval_i;
      lv_q <= lval_i;
    end
  end

  always_comb begin
    frame_start = fval_i & ~fv_q;
    frame_end   = ~fval_i & fv_q;
    lv_rise     = lval_i & ~lv_q;
    lv_fall     = ~lval_i & lv_q;
  end

  fgm_line_clk_cnt #(.CNT_W(CNT_W)) i_line_clk (
    .clk(clk), .rst_n(rst_sync_n), .lv(lval_i), .dv(dval_i),
    .lv_rise(lv_rise), .lv_fall(lv_fall), .frame_start(frame_start),
    .line_clks(cur_clks)
  );

  fgm_line_num_cnt #(.CNT_W(CNT_W)) i_line_num (
    .clk(clk), .rst_n(rst_sync_n), .fv(fval_i), .lv_rise(lv_rise),
    .frame_start(frame_start), .lines(cur_lines)
  );

  fgm_result_reg #(
    .CNT_W(CNT_W), .PIX_W(PIX_W), .TOT_W(TOT_W), .FCNT_W(FCNT_W), .ALN_W(ALN_W)
  ) i_result (
    .clk(clk), .rst_n(rst_sync_n), .frame_end(frame_end),
    .line_clks(cur_clks), .line_num(cur_lines), .tap_raw(tap_cnt_i),
    .exp_width(exp_width_i), .exp_height(exp_height_i),
    .clks_q(line_clks_o), .lines_q(frame_lines_o), .ppl_q(line_pixels_o),
    .total_q(frame_pixels_o), .werr_q(width_err_o), .herr_q(height_err_o),
    .align_q(align_ok_o), .done_q(frame_done_o), .fcnt_q(frame_cnt_o)
  );

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start && !lval_i |=> cur_lines == '0 && cur_clks == '0);
endmodule

// File: tb/test_frame_geom_mon.sv
module test_frame_geom_mon;
  localparam int CW = 16;
  localparam int PW = 20;
  localparam int TW = 32;
  localparam int FW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, fval, lval, dval;
  logic [3:0]    tap;
  logic [PW-1:0] exp_w;
  logic [CW-1:0] exp_h;
  logic [CW-1:0] clks_o, lines_o;
  logic [PW-1:0] ppl_o;
  logic [TW-1:0] total_o;
  logic          werr_o, herr_o, align_o, done_o;
  logic [FW-1:0] fcnt_o;

  frame_geom_mon #(.CNT_W(CW), .TOT_W(TW), .FCNT_W(FW)) i_frame_geom_mon (
    .clk(clk), .rst_n(rst_n), .fval_i(fval), .lval_i(lval), .dval_i(dval),
    .tap_cnt_i(tap), .exp_width_i(exp_w), .exp_height_i(exp_h),
    .line_clks_o(clks_o), .frame_lines_o(lines_o), .line_pixels_o(ppl_o),
    .frame_pixels_o(total_o), .width_err_o(werr_o), .height_err_o(herr_o),
    .align_ok_o(align_o), .frame_done_o(done_o), .frame_cnt_o(fcnt_o)
  );

  typedef struct {
    longint clks, lines, ppl, total, wm, hm, al, fc;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;
  int   checks = 0;
  int   fails  = 0;
  int   fc_model = 0;
  bit   ended = 1'b0;

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: pushes the expected frame result, then drives the strobes.
  task automatic send_frame(int c, int lastc, int nl, int tp, int ew, int eh,
                            int stall, bit stray);
    exp_t e;
    int teff;
    teff = (tp == 0) ? 1 : (tp > 10) ? 10 : tp;
    e.clks  = (nl == 0) ? 0 : lastc;
    e.lines = nl;
    e.ppl   = e.clks * teff;
    e.total = (e.ppl * nl) & 64'hFFFF_FFFF;
    e.wm    = (e.ppl != ew);
    e.hm    = (nl != eh);
    e.al    = ((e.clks % 16) == 0) || ((nl % 16) == 0);
    fc_model = (fc_model + 1) % (1 << FW);
    e.fc    = fc_model;
    sb.push_back(e);
    @(negedge clk);
    tap   = 4'(tp);
    exp_w = PW'(ew);
    exp_h = CW'(eh);
    if (stray) begin                 // R10: line pulse outside the frame
      lval = 1'b1; dval = 1'b1;
      repeat (5) @(negedge clk);
      lval = 1'b0; dval = 1'b0;
      repeat (2) @(negedge clk);
    end
    fval = 1'b1;
    @(negedge clk);
    for (int l = 0; l < nl; l++) begin
      int n;
      n = (l == nl - 1) ? lastc : c;
      lval = 1'b1;
      for (int i = 0; i < n; i++) begin
        if (stall > 0 && i > 0 && (i % stall) == 0) begin
          dval = 1'b0;
          @(negedge clk);
        end
        dval = 1'b1;
        @(negedge clk);
      end
      lval = 1'b0; dval = 1'b0;
      repeat (2) @(negedge clk);
    end
    fval = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops and compares on each done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk("R6", "unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        last_exp = e;
        chk("R2",  "line_clks",    clks_o,  e.clks);
        chk("R3",  "frame_lines",  lines_o, e.lines);
        chk("R4",  "line_pixels",  ppl_o,   e.ppl);
        chk("R5",  "frame_pixels", total_o, e.total);
        chk("R7",  "width_err",    werr_o,  e.wm);
        chk("R7",  "height_err",   herr_o,  e.hm);
        chk("R8",  "align_ok",     align_o, e.al);
        chk("R9",  "frame_cnt",    fcnt_o,  e.fc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fval = 1'b0; lval = 1'b0; dval = 1'b0;
    tap = 4'd1; exp_w = '0; exp_h = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "frame_cnt in reset", fcnt_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "line_clks after reset", clks_o, 0);
    chk("R1", "frame_pixels after reset", total_o, 0);
    chk("R1", "align after reset", align_o, 0);
    chk("R1", "done after reset", done_o, 0);

    send_frame(204, 204, 16, 10, 2040, 16, 0, 1'b0); // wide line, 16 lines
    send_frame(20, 20, 5, 3, 60, 6, 3, 1'b0);        // height mismatch, misaligned
    send_frame(32, 32, 3, 0, 33, 3, 0, 1'b0);        // tap 0 -> 1, width mismatch
    send_frame(7, 7, 2, 15, 70, 2, 2, 1'b0);         // tap 15 -> 10
    send_frame(9, 5, 4, 2, 10, 4, 0, 1'b1);          // last line differs, stray pulse
    send_frame(16, 16, 3, 4, 64, 3, 5, 1'b1);        // aligned by width
    for (int k = 0; k < 12; k++)
      send_frame(k + 1, k + 1, (k % 3) + 1, k % 12, (k + 1) * 2, 2, k % 4, k[0]);

    // R6: results hold after the last frame
    repeat (6) @(negedge clk);
    chk("R6", "hold frame_lines", lines_o, last_exp.lines);
    chk("R6", "hold frame_pixels", total_o, last_exp.total);
    chk("R6", "no extra done", done_o, 0);
    chk("R6", "scoreboard drained", sb.size(), 0);

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule